// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two tables of 2-bit saturating counters and reads both in the same cycle. The first table is indexed by the branch address alone. The second is indexed by the branch address XORed with a shift register that holds the most recent resolved outcomes. A third counter table, indexed by the branch address, decides which of the two guesses is sent out. The lookup is purely combinational from the presented PC, so fetch gets a direction in the same cycle.

With every prediction the block hands out a snapshot word. The snapshot holds the history-hashed index, both component directions and the component that was chosen. The pipeline carries this word with the branch and gives it back, together with the real outcome, on the resolve port. Both direction counters are then trained at the indices that were used at predict time, the selector is nudged, and the history register takes in the outcome. One cycle after each resolve the block reports two things: which component supplied the prediction, and whether that prediction was wrong. An external power-gating controller uses this report to decide which table it can switch off for that branch next time.

Top module: `hybrid_dir_pred`

## Requirements
- R1: After reset every direction counter holds 01 and every selector counter holds 01, and the history register is zero. As a result `predTaken` and `predUseGsh` are 0 for any PC, and `repValid` is 0.
- R2: Every counter is 2 bits wide and saturates at 0 and at 3. Its upper bit is the direction: 1 means taken. A not-taken outcome at 0 leaves the counter at 0, and a taken outcome at 3 leaves it at 3.
- R3: The address-only table is indexed by `PC[IDX_W+1:2]`. Snapshot bit 1 carries that table's direction.
- R4: The snapshot is `{gshIdx, useGsh, bimDir, gshDir}`. `gshIdx` sits in bits `[IDX_W+2:3]` and equals `PC[IDX_W+1:2] ^ history` at predict time. `useGsh` is bit 2, `bimDir` is bit 1 and `gshDir` is bit 0. On resolve, the history-hashed table is trained at the index taken from the snapshot.
- R5: The selector counter's upper bit picks the component: 1 selects the history-hashed table. `predTaken` equals the chosen component's direction, and `predUseGsh` shows which component was chosen.
- R6: On resolve the selector entry at `resPc`'s index moves one step toward the component that matched the outcome. It moves only when exactly one of the two snapshot directions was correct.
- R7: Each resolve shifts the actual outcome into bit 0 of the history register. Without a resolve the register keeps its value.
- R8: One cycle after a resolve, `repValid` is 1. `repUsedGsh` is the snapshot's `useGsh`, and `repMiss` is 1 exactly when the chosen snapshot direction differs from `resTaken`. In a cycle with no resolve before it, `repValid` is 0.
- R9: In a branch that is taken seven times and then not taken once, over and over, the address-only table mispredicts once per period after warm-up.
- R10: When a predict and a resolve occur in the same cycle, the prediction reads the table state from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| predPc | input | PC_W | Address of the branch being looked up |
| predTaken | output | 1 | Predicted direction, 1 means taken |
| predUseGsh | output | 1 | 1 when the history-hashed component was chosen |
| predSnap | output | IDX_W+3 | Prediction snapshot to carry with the branch |
| resValid | input | 1 | A branch resolves in this cycle |
| resPc | input | PC_W | Address of the resolving branch |
| resTaken | input | 1 | Actual outcome of the resolving branch |
| resSnap | input | IDX_W+3 | Snapshot returned with the resolving branch |
| repValid | output | 1 | Report for the previous cycle's resolve is present |
| repMiss | output | 1 | The reported branch was mispredicted |
| repUsedGsh | output | 1 | The reported branch used the history-hashed component |

## Verification
The properties assume that `resSnap` is a word this block produced for the same PC. They also assume that `resValid` is a clean level sampled at the clock edge. If a snapshot were forged or mismatched, the miss flag would still follow the snapshot, but the trained entries would not correspond to any real lookup. The stimulus only ever resolves snapshots it obtained from the predict port for that PC. In the mixed phase it keeps them in a first-in, first-out queue, so out-of-order or invented snapshots never reach the resolve port.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

  localparam logic [1:0] CNT_WEAK_NT  = 2'b01;
  localparam logic [1:0] SEL_WEAK_BIM = 2'b01;

  // Strobes from control to datapath for one resolve
  typedef struct packed {
    logic dirWr;     // train both direction counters
    logic dirUp;     // direction of training
    logic selWr;     // move selector
    logic selUp;     // toward the history-hashed component
    logic histShift; // shift outcome into history
  } hdp_upd_t;

  function automatic logic [1:0] satStep(input logic [1:0] cnt, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cnt == 2'b11) ? cnt : cnt + 2'b01;
    else    nxt = (cnt == 2'b00) ? cnt : cnt - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/hdp_ctr_table.sv
module hdp_ctr_table #(
  parameter int         IDX_W = 8,
  parameter logic [1:0] INIT  = 2'b01
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [1:0]       rdCnt,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUp
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] cnt [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= INIT;
    end else if (wrEn) begin
      cnt[wrIdx] <= hdp_pkg::satStep(cnt[wrIdx], wrUp);
    end
  end

  assign rdCnt = cnt[rdIdx];

endmodule

// File: rtl/hdp_datapath.sv
module hdp_datapath
  import hdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  predPc,
  input  logic [PC_W-1:0]  resPc,
  input  logic [IDX_W-1:0] resGshIdx,
  input  logic             resTaken,
  input  hdp_upd_t         upd,
  output logic             bimDir,
  output logic             gshDir,
  output logic             useGsh,
  output logic [IDX_W-1:0] gshIdx,
  output logic [IDX_W-1:0] ghr
);
  localparam int LO = 2;
  localparam int HI = IDX_W + LO - 1;

  logic [IDX_W-1:0] predIdx, resIdx;
  logic [1:0] bimCnt, gshCnt, selCnt;

  assign predIdx = predPc[HI:LO];
  assign resIdx  = resPc[HI:LO];
  assign gshIdx  = predIdx ^ ghr;

  hdp_ctr_table #(.IDX_W(IDX_W), .INIT(CNT_WEAK_NT)) u_bimTab (
    .clk(clk), .rstN(rstN),
    .rdIdx(predIdx), .rdCnt(bimCnt),
    .wrEn(upd.dirWr), .wrIdx(resIdx), .wrUp(upd.dirUp)
  );

  hdp_ctr_table #(.IDX_W(IDX_W), .INIT(CNT_WEAK_NT)) u_gshTab (
    .clk(clk), .rstN(rstN),
    .rdIdx(gshIdx), .rdCnt(gshCnt),
    .wrEn(upd.dirWr), .wrIdx(resGshIdx), .wrUp(upd.dirUp)
  );

  hdp_ctr_table #(.IDX_W(IDX_W), .INIT(SEL_WEAK_BIM)) u_selTab (
    .clk(clk), .rstN(rstN),
    .rdIdx(predIdx), .rdCnt(selCnt),
    .wrEn(upd.selWr), .wrIdx(resIdx), .wrUp(upd.selUp)
  );

  assign bimDir = bimCnt[1];
  assign gshDir = gshCnt[1];
  assign useGsh = selCnt[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ghr <= '0;
    else if (upd.histShift) ghr <= {ghr[IDX_W-2:0], resTaken};
  end

endmodule

// File: rtl/hdp_ctrl.sv
module hdp_ctrl
  import hdp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resValid,
  input  logic     resTaken,
  input  logic     snapUseGsh,
  input  logic     snapBimDir,
  input  logic     snapGshDir,
  output hdp_upd_t upd,
  output logic     repValid,
  output logic     repMiss,
  output logic     repUsedGsh
);
  logic bimOk, gshOk, chosenDir;

  assign bimOk     = (snapBimDir == resTaken);
  assign gshOk     = (snapGshDir == resTaken);
  assign chosenDir = snapUseGsh ? snapGshDir : snapBimDir;

  always_comb begin
    upd.dirWr     = resValid;
    upd.dirUp     = resTaken;
    upd.selWr     = resValid && (bimOk != gshOk);
    upd.selUp     = gshOk;
    upd.histShift = resValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      repValid   <= 1'b0;
      repMiss    <= 1'b0;
      repUsedGsh <= 1'b0;
    end else begin
      repValid   <= resValid;
      repMiss    <= resValid && (chosenDir != resTaken);
      repUsedGsh <= resValid && snapUseGsh;
    end
  end

endmodule

// File: rtl/hybrid_dir_pred.sv
module hybrid_dir_pred
  import hdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8,
  localparam int SNAP_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  output logic              predUseGsh,
  output logic [SNAP_W-1:0] predSnap,
  input  logic              resValid,
  input  logic [PC_W-1:0]   resPc,
  input  logic              resTaken,
  input  logic [SNAP_W-1:0] resSnap,
  output logic              repValid,
  output logic              repMiss,
  output logic              repUsedGsh
);
  hdp_upd_t         upd;
  logic             bimDir, gshDir, useGsh;
  logic [IDX_W-1:0] gshIdx, ghr;

  hdp_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .predPc(predPc), .resPc(resPc),
    .resGshIdx(resSnap[SNAP_W-1:3]), .resTaken(resTaken),
    .upd(upd),
    .bimDir(bimDir), .gshDir(gshDir), .useGsh(useGsh),
    .gshIdx(gshIdx), .ghr(ghr)
  );

  hdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .resValid(resValid), .resTaken(resTaken),
    .snapUseGsh(resSnap[2]), .snapBimDir(resSnap[1]), .snapGshDir(resSnap[0]),
    .upd(upd),
    .repValid(repValid), .repMiss(repMiss), .repUsedGsh(repUsedGsh)
  );

  assign predUseGsh = useGsh;
  assign predTaken  = useGsh ? gshDir : bimDir;
  assign predSnap   = {gshIdx, useGsh, bimDir, gshDir};

endmodule

// File: rtl/hybrid_dir_pred_chk.sv
module hybrid_dir_pred_chk #(
  parameter int IDX_W = 8,
  parameter int PC_W  = 32,
  localparam int SNAP_W = IDX_W + 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   predPc,
  input logic [SNAP_W-1:0] predSnap,
  input logic              resValid,
  input logic              resTaken,
  input logic [SNAP_W-1:0] resSnap,
  input logic [IDX_W-1:0]  ghr,
  input logic              repValid,
  input logic              repMiss,
  input logic              repUsedGsh
);
  // R1
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (ghr == '0));

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> (ghr == {$past(ghr[IDX_W-2:0]), $past(resTaken)}));

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |=> $stable(ghr));

  // R8
  rep_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> repValid);

  // R8
  rep_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |=> !repValid);

  // R8
  rep_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> (repMiss == (($past(resSnap[2]) ? $past(resSnap[0]) : $past(resSnap[1]))
                              != $past(resTaken))));

  // R8
  rep_comp_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> (repUsedGsh == $past(resSnap[2])));

  // R4
  snap_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    predSnap[SNAP_W-1:3] == (predPc[IDX_W+1:2] ^ ghr));

endmodule

bind hybrid_dir_pred hybrid_dir_pred_chk #(.IDX_W(IDX_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .predPc(predPc), .predSnap(predSnap),
  .resValid(resValid), .resTaken(resTaken), .resSnap(resSnap), .ghr(ghr),
  .repValid(repValid), .repMiss(repMiss), .repUsedGsh(repUsedGsh)
);

// File: tb/hybrid_dir_pred_bench.sv
module hybrid_dir_pred_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 8;
  localparam int SNAP_W = IDX_W + 3;
  localparam int NENT   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] predPc = '0, resPc = '0;
  logic resValid = 1'b0, resTaken = 1'b0;
  logic [SNAP_W-1:0] resSnap = '0;
  logic predTaken, predUseGsh, repValid, repMiss, repUsedGsh;
  logic [SNAP_W-1:0] predSnap;

  always #(CLK_PERIOD/2) clk = ~clk;

  hybrid_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hybrid_dir_pred (
    .clk(clk), .rstN(rstN),
    .predPc(predPc), .predTaken(predTaken), .predUseGsh(predUseGsh), .predSnap(predSnap),
    .resValid(resValid), .resPc(resPc), .resTaken(resTaken), .resSnap(resSnap),
    .repValid(repValid), .repMiss(repMiss), .repUsedGsh(repUsedGsh)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  int bimM [NENT];
  int gshM [NENT];
  int selM [NENT];
  int ghrM;
  bit repVM, repMM, repGM;
  logic [SNAP_W-1:0] lastSnap;
  int dutMissSeen = 0;

  function automatic int idxOf(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic int satM(input int c, input bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NENT; i++) begin
      bimM[i] = 1; gshM[i] = 1; selM[i] = 1;
    end
    ghrM = 0; repVM = 0; repMM = 0; repGM = 0;
  endtask

  // One clock: drive, compare against the model, then advance the model
  task automatic cyc(input logic [PC_W-1:0] ppc, input bit rv,
                     input logic [PC_W-1:0] rpc, input bit rt,
                     input logic [SNAP_W-1:0] rs, input string tag);
    int pi, gi, ri, gr;
    bit bd, gd, ug, et;
    logic [SNAP_W-1:0] es;
    @(negedge clk);
    predPc = ppc; resValid = rv; resPc = rpc; resTaken = rt; resSnap = rs;
    #1;
    pi = idxOf(ppc);
    gi = pi ^ ghrM;
    bd = (bimM[pi] >= 2); gd = (gshM[gi] >= 2); ug = (selM[pi] >= 2);
    et = ug ? gd : bd;
    es = {IDX_W'(gi), ug, bd, gd};
    lastSnap = es;
    chk(predTaken == et, {tag, " R5 predTaken"}, predTaken, et);
    chk(predUseGsh == ug, {tag, " R5 predUseGsh"}, predUseGsh, ug);
    chk(predSnap == es, {tag, " R3/R4 predSnap"}, int'(predSnap), int'(es));
    chk(repValid == repVM, {tag, " R8 repValid"}, repValid, repVM);
    if (repVM) begin
      chk(repMiss == repMM, {tag, " R8 repMiss"}, repMiss, repMM);
      chk(repUsedGsh == repGM, {tag, " R8 repUsedGsh"}, repUsedGsh, repGM);
    end
    if (repValid && repMiss) dutMissSeen++;
    @(posedge clk);
    repVM = rv;
    if (rv) begin
      ri = idxOf(rpc);
      gr = int'(rs[SNAP_W-1:3]);
      repMM = ((rs[2] ? rs[0] : rs[1]) != rt);
      repGM = rs[2];
      bimM[ri] = satM(bimM[ri], rt);
      gshM[gr] = satM(gshM[gr], rt);
      if ((rs[1] == rt) != (rs[0] == rt)) selM[ri] = satM(selM[ri], rs[0] == rt);
      ghrM = ((ghrM << 1) | int'(rt)) & (NENT - 1);
    end
  endtask

  // Predict in one cycle, resolve in the next
  task automatic branch(input logic [PC_W-1:0] pc, input bit t, input string tag);
    logic [SNAP_W-1:0] s;
    cyc(pc, 0, '0, 0, '0, tag);
    s = lastSnap;
    cyc(pc, 1, pc, t, s, tag);
  endtask

  logic [SNAP_W-1:0] qSnap [$];
  logic [PC_W-1:0]   qPc [$];

  initial begin
    logic [31:0] lfsr;
    int missBase, bimMiss;
    logic [SNAP_W-1:0] s;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state seen at the ports for several addresses
    for (int k = 0; k < 4; k++) begin
      cyc(32'h40 * k + 32'h4, 0, '0, 0, '0, "reset");
      chk(predTaken == 1'b0, "R1 predTaken after reset", predTaken, 0);
      chk(predUseGsh == 1'b0, "R1 predUseGsh after reset", predUseGsh, 0);
      chk(repValid == 1'b0, "R1 repValid after reset", repValid, 0);
    end

    // R10: predict and resolve of the same branch in one cycle
    cyc(32'h100, 0, '0, 0, '0, "r10_a");
    s = lastSnap;
    cyc(32'h100, 1, 32'h100, 1, s, "r10_b");
    chk(predTaken == 1'b0, "R10 same-cycle reads old state", predTaken, 0);
    cyc(32'h100, 0, '0, 0, '0, "r10_c");
    chk(predSnap[1] == 1'b1, "R10 update visible next cycle", predSnap[1], 1);

    // R2: saturation at 0, then one taken stays not-taken
    for (int k = 0; k < 4; k++) branch(32'h200, 0, "r2_sat");
    branch(32'h200, 1, "r2_sat");
    cyc(32'h200, 0, '0, 0, '0, "r2_chk");
    chk(predSnap[1] == 1'b0, "R2 saturated at 0 then one taken", predSnap[1], 0);
    for (int k = 0; k < 5; k++) branch(32'h200, 1, "r2_top");
    branch(32'h200, 0, "r2_top");
    cyc(32'h200, 0, '0, 0, '0, "r2_chk2");
    chk(predSnap[1] == 1'b1, "R2 saturated at 3 then one not-taken", predSnap[1], 1);

    // R9: seven taken, one not taken, repeated; bimodal misses once per period
    bimMiss = 0;
    for (int p = 0; p < 6; p++) begin
      for (int j = 0; j < 8; j++) begin
        bit t;
        t = (j != 7);
        cyc(32'h300, 0, '0, 0, '0, "r9");
        s = lastSnap;
        if (p >= 3 && (predSnap[1] != t)) bimMiss++;
        cyc(32'h300, 1, 32'h300, t, s, "r9");
      end
    end
    chk(bimMiss == 3, "R9 one miss per rare outcome", bimMiss, 3);

    // R6/R4: period-4 pattern learned by the history-hashed table
    for (int p = 0; p < 40; p++) begin
      for (int j = 0; j < 4; j++) begin
        if (p == 38 && j == 0) missBase = dutMissSeen;
        branch(32'h400, j != 3, "r6");
      end
    end
    cyc(32'h400, 0, '0, 0, '0, "r6_end");
    chk(dutMissSeen == missBase, "R6 no misses after training", dutMissSeen - missBase, 0);
    chk(predUseGsh == 1'b1, "R6 selector moved to history table", predUseGsh, 1);

    // R7/R8: mixed traffic with queued snapshots
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] pc;
      bit doRes, t;
      logic [PC_W-1:0] rpc;
      logic [SNAP_W-1:0] rsn;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pc = {22'h0, lfsr[5:0], 4'h0} + {30'h0, lfsr[7:6]} * 4;
      doRes = lfsr[9] && (qPc.size() > 0);
      t = lfsr[12] | lfsr[13];
      rpc = doRes ? qPc[0] : '0;
      rsn = doRes ? qSnap[0] : '0;
      if (doRes) begin
        void'(qPc.pop_front());
        void'(qSnap.pop_front());
      end
      cyc(pc, doRes, rpc, t, rsn, "mix");
      if (qPc.size() < 8) begin
        qPc.push_back(pc);
        qSnap.push_back(lastSnap);
      end
    end
    cyc('0, 0, '0, 0, '0, "tail");
    cyc('0, 0, '0, 0, '0, "tail");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule